// File: doc/BRIEF.md
# Accumulator Processor Execution Core

This block is a small 16-bit processor built around a single accumulator. It fetches two-byte instructions from a memory that holds both program and data, decodes a five-bit operation and a ten-bit operand field, and carries out one of eight operations. The accumulator is the implicit source and destination of every arithmetic and logic operation. Stores and loads use the operand field as a byte address. A single conditional branch tests the accumulator's sign bit.

The core talks to a synchronous memory through a byte address, a write-data word, a read-data word and a two-bit operation code. Read data arrives on the cycle after the read request, and a write takes effect at the clock edge on which the write code is presented. Program and data share one address space. A program that must stop ends with a jump to its own address.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low the memory operation code is 00 (no operation). After `rst_n` rises, the first memory request is a read of byte address 0, and the accumulator starts at 0.
- R2: The instruction word carries the indirect flag in bit 15, the opcode in bits 14:10 and the operand X in bits 9:0. An instruction with bit 15 set executes exactly as the same instruction with bit 15 clear.
- R3: Each fetch reads at the program counter, which then advances by 2. A non-memory instruction takes three cycles from one fetch request to the next. A store takes the same three cycles and writes in the third. A load takes four cycles and issues its read in the third.
- R4: Opcode 00000 replaces the accumulator with its bitwise complement.
- R5: Opcode 00001 shifts the accumulator right by one place and fills bit 15 with 0, even when the accumulator is negative.
- R6: Opcode 00110 ANDs the accumulator with X zero-extended to 16 bits. Opcode 00111 adds zero-extended X to the accumulator modulo 2^16.
- R7: Opcode 00010 loads the program counter with X when accumulator bit 15 is 1. When bit 15 is 0, execution continues at the next instruction.
- R8: Opcode 00011 always loads the program counter with X.
- R9: Opcode 00100 issues a write of the accumulator to byte address X and leaves the accumulator unchanged.
- R10: Opcode 00101 issues a read of byte address X and places the returned word in the accumulator.
- R11: The memory operation code is 00 for no operation, 01 for read and 10 for write. The value 11 never appears.
- R12: An opcode outside 00000..00111 changes neither the accumulator nor memory, and execution continues at the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 10 | Byte address of the current memory request |
| mem_wdata | output | 16 | Data word written on a write request |
| mem_rdata | input | 16 | Data word returned one cycle after a read request |
| mem_op | output | 2 | Memory operation: 00 none, 01 read, 10 write |

## Verification
A shift of a negative accumulator is aimed at a design that shifts arithmetically; such a design would store 0xC102 where 0x4102 is expected. A branch is tested both with the sign bit clear and with it set. A design that inverts the test would run into a guarded store that must never happen, or would fetch from the wrong address. An addition that wraps past 0xFFFF, an AND with a mask wider than nine bits, an instruction with the indirect flag set and an undefined opcode each leave a value in memory that exposes sign-extension, a bad carry, flag misdecoding or a stray accumulator write. A scoreboard compares every memory request, with its cycle spacing, against an instruction-level model. A wrong step size, a lost load cycle or a misplaced write therefore shows up at the first instruction that goes wrong.

// File: rtl/acc_pkg.sv
// Package: shared encodings for the accumulator core.
// Holds opcode constants, memory operation codes, sequencer states,
// ALU selections and the bundle of control points the sequencer drives.
package acc_pkg;

    // Opcode field values (instruction bits 14:10)
    localparam logic [4:0] OPC_CMPL  = 5'b00000;
    localparam logic [4:0] OPC_SHR   = 5'b00001;
    localparam logic [4:0] OPC_BNEG  = 5'b00010;
    localparam logic [4:0] OPC_JUMP  = 5'b00011;
    localparam logic [4:0] OPC_STORE = 5'b00100;
    localparam logic [4:0] OPC_LOAD  = 5'b00101;
    localparam logic [4:0] OPC_ANDI  = 5'b00110;
    localparam logic [4:0] OPC_ADDI  = 5'b00111;

    // Memory request codes seen on the bus
    typedef enum logic [1:0] {
        MOP_NOP = 2'b00,
        MOP_RD  = 2'b01,
        MOP_WR  = 2'b10
    } mop_t;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_RESET,
        ST_FETCH,
        ST_LATCH,
        ST_EXEC,
        ST_LDWAIT
    } state_t;

    // ALU function selection
    typedef enum logic [2:0] {
        ALU_NOT,
        ALU_SHR,
        ALU_AND,
        ALU_ADD,
        ALU_PASS
    } alu_op_t;

    // Control points driven by the sequencer each cycle
    typedef struct packed {
        logic    pc_inc;
        logic    pc_load;
        logic    ir_load;
        logic    ac_load;
        logic    b_from_mem;
        logic    addr_from_ir;
        alu_op_t alu_op;
        mop_t    mem_op;
    } ctrl_t;

endpackage

// File: rtl/acc_alu.sv
// Module: acc_alu
// Combinational ALU between the accumulator (a) and a second operand (b).
// Assumes b is already zero-extended or comes from memory; the shift is
// logical and the addition wraps modulo 2^WORD_W.
module acc_alu
    import acc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  alu_op_t            op,
    input  logic [WORD_W-1:0]  a,
    input  logic [WORD_W-1:0]  b,
    output logic [WORD_W-1:0]  y
);

    // Select the result for the requested function
    always_comb begin
        case (op)
            ALU_NOT: y = ~a;
            ALU_SHR: y = {1'b0, a[WORD_W-1:1]};
            ALU_AND: y = a & b;
            ALU_ADD: y = a + b;
            default: y = b;
        endcase
    end

endmodule

// File: rtl/acc_pc.sv
// Module: acc_pc
// Program counter. Clears on reset, loads a target when asked, otherwise
// steps by STEP bytes when asked. Load wins over increment.
module acc_pc #(
    parameter int ADDR_W = 10,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc_q
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Hold, load or advance the program counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= '0;
        else if (load)
            pc_q <= target;
        else if (inc)
            pc_q <= pc_q + STEP_V;
    end

endmodule

// File: rtl/acc_ctrl.sv
// Module: acc_ctrl
// Instruction sequencer. Walks fetch, latch and execute states (plus one
// wait state for loads) and drives every datapath control point. Assumes
// memory returns read data on the cycle after the request.
module acc_ctrl
    import acc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] opcode,
    input  logic       ac_neg,
    output state_t     state_q,
    output ctrl_t      ctl
);

    state_t state_d;

    // Advance the sequencer state
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RESET;
        else
            state_q <= state_d;
    end

    // Choose the next state from the current state and opcode
    always_comb begin
        case (state_q)
            ST_RESET:  state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_LATCH;
            ST_LATCH:  state_d = ST_EXEC;
            ST_EXEC:   state_d = (opcode == OPC_LOAD) ? ST_LDWAIT : ST_FETCH;
            ST_LDWAIT: state_d = ST_FETCH;
            default:   state_d = ST_RESET;
        endcase
    end

    // Drive control points for the current state
    always_comb begin
        ctl = '0;
        ctl.alu_op = ALU_PASS;
        ctl.mem_op = MOP_NOP;
        case (state_q)
            ST_FETCH: begin
                ctl.pc_inc = 1'b1;
                ctl.mem_op = MOP_RD;
            end
            ST_LATCH: ctl.ir_load = 1'b1;
            ST_EXEC: begin
                case (opcode)
                    OPC_CMPL: begin
                        ctl.ac_load = 1'b1;
                        ctl.alu_op  = ALU_NOT;
                    end
                    OPC_SHR: begin
                        ctl.ac_load = 1'b1;
                        ctl.alu_op  = ALU_SHR;
                    end
                    OPC_BNEG:  ctl.pc_load = ac_neg;
                    OPC_JUMP:  ctl.pc_load = 1'b1;
                    OPC_STORE: begin
                        ctl.addr_from_ir = 1'b1;
                        ctl.mem_op       = MOP_WR;
                    end
                    OPC_LOAD: begin
                        ctl.addr_from_ir = 1'b1;
                        ctl.mem_op       = MOP_RD;
                    end
                    OPC_ANDI: begin
                        ctl.ac_load = 1'b1;
                        ctl.alu_op  = ALU_AND;
                    end
                    OPC_ADDI: begin
                        ctl.ac_load = 1'b1;
                        ctl.alu_op  = ALU_ADD;
                    end
                    default: ;
                endcase
            end
            ST_LDWAIT: begin
                ctl.ac_load    = 1'b1;
                ctl.b_from_mem = 1'b1;
                ctl.alu_op     = ALU_PASS;
            end
            default: ;
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (ctl.mem_op == MOP_NOP)); // R1
    AST_NO_RESERVED_OP: assert property (@(posedge clk) disable iff (!rst_n) ctl.mem_op != 2'b11); // R11

endmodule

// File: rtl/acc_core.sv
// Module: acc_core
// Top of the accumulator processor. Holds the instruction and accumulator
// registers, selects the memory address and ALU operand, and wires the
// program counter and sequencer. Assumes a synchronous memory with one
// cycle of read latency; the indirect flag (bit WORD_W-1) is not decoded.
module acc_core
    import acc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [WORD_W-7:0]     mem_addr,
    output logic [WORD_W-1:0]     mem_wdata,
    input  logic [WORD_W-1:0]     mem_rdata,
    output logic [1:0]            mem_op
);

    localparam int OPC_W       = 5;
    localparam int ADDR_W      = WORD_W - 1 - OPC_W;
    localparam int INSTR_BYTES = WORD_W / 8;

    state_t              state_q;
    ctrl_t               ctl;
    logic [WORD_W-2:0]   ir_q;
    logic [WORD_W-1:0]   ac_q;
    logic [WORD_W-1:0]   alu_b;
    logic [WORD_W-1:0]   alu_y;
    logic [ADDR_W-1:0]   pc_q;
    logic [ADDR_W-1:0]   x_fld;
    logic [OPC_W-1:0]    opcode;

    assign x_fld  = ir_q[ADDR_W-1:0];
    assign opcode = ir_q[WORD_W-2 -: OPC_W];

    acc_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (opcode),
        .ac_neg  (ac_q[WORD_W-1]),
        .state_q (state_q),
        .ctl     (ctl)
    );

    acc_pc #(
        .ADDR_W (ADDR_W),
        .STEP   (INSTR_BYTES)
    ) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (ctl.pc_inc),
        .load   (ctl.pc_load),
        .target (x_fld),
        .pc_q   (pc_q)
    );

    // Second ALU operand: memory word for loads, zero-extended X otherwise
    always_comb begin
        if (ctl.b_from_mem)
            alu_b = mem_rdata;
        else
            alu_b = {{(WORD_W-ADDR_W){1'b0}}, x_fld};
    end

    acc_alu #(
        .WORD_W (WORD_W)
    ) u_alu (
        .op (ctl.alu_op),
        .a  (ac_q),
        .b  (alu_b),
        .y  (alu_y)
    );

    // Capture the fetched instruction (flag bit is not kept)
    always_ff @(posedge clk) begin
        if (!rst_n)
            ir_q <= '0;
        else if (ctl.ir_load)
            ir_q <= mem_rdata[WORD_W-2:0];
    end

    // Update the accumulator from the ALU
    always_ff @(posedge clk) begin
        if (!rst_n)
            ac_q <= '0;
        else if (ctl.ac_load)
            ac_q <= alu_y;
    end

    assign mem_addr  = ctl.addr_from_ir ? x_fld : pc_q;
    assign mem_wdata = ac_q;
    assign mem_op    = ctl.mem_op;

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (pc_q == $past(mem_addr) + ADDR_W'(INSTR_BYTES))); // R3
    AST_STORE_HOLDS_AC: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_op == MOP_WR) |=> $stable(ac_q)); // R9
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LDWAIT) |=> (ac_q == $past(mem_rdata))); // R10
    AST_BNEG_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && opcode == OPC_BNEG && !ac_q[WORD_W-1]) |=> (pc_q == $past(pc_q))); // R7
    AST_SHR_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && opcode == OPC_SHR) |=> !ac_q[WORD_W-1]); // R5

endmodule

// File: tb/tb_acc_core.sv
module tb_acc_core;

    typedef struct {
        logic [1:0]  op;
        logic [9:0]  addr;
        logic [15:0] data;
        int          gap;
        string       req;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [1:0]  mem_op;

    logic [15:0] mem     [0:511];
    logic [15:0] ref_mem [0:511];
    sb_item_t    sb [$];

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    int  last_cyc = 0;
    bit  mon_en = 1'b0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    acc_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_op    (mem_op)
    );

    // Synchronous memory: read data one cycle later, write at the edge
    always @(posedge clk) begin
        if (mem_op == 2'b01) mem_rdata <= mem[mem_addr[9:1]];
        if (mem_op == 2'b10) mem[mem_addr[9:1]] = mem_wdata;
    end

    function automatic void check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    function automatic logic [15:0] enc(bit ind, logic [4:0] opc, logic [9:0] x);
        return {ind, opc, x};
    endfunction

    task automatic put(int baddr, logic [15:0] w);
        mem[baddr/2]     = w;
        ref_mem[baddr/2] = w;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 512; i++) begin
            mem[i]     = 16'hDEAD;
            ref_mem[i] = 16'hDEAD;
        end
    endtask

    task automatic push(logic [1:0] op, logic [9:0] a, logic [15:0] d, int gap, string req);
        sb_item_t it;
        it.op = op; it.addr = a; it.data = d; it.gap = gap; it.req = req;
        sb.push_back(it);
    endtask

    // Instruction-level model: pushes the expected bus requests
    task automatic model_run(int n);
        logic [9:0]  rpc = '0;
        logic [15:0] rac = '0;
        int          gap = 0;
        for (int k = 0; k < n; k++) begin
            logic [15:0] ir;
            logic [9:0]  x;
            ir = ref_mem[rpc[9:1]];
            x  = ir[9:0];
            push(2'b01, rpc, 16'h0, gap, (k == 0) ? "R1" : "R3");
            rpc = rpc + 10'd2;
            gap = 3;
            case (ir[14:10])
                5'b00000: rac = ~rac;
                5'b00001: rac = rac >> 1;
                5'b00010: if (rac[15]) rpc = x;
                5'b00011: rpc = x;
                5'b00100: begin
                    push(2'b10, x, rac, 2, "R9");
                    ref_mem[x[9:1]] = rac;
                    gap = 1;
                end
                5'b00101: begin
                    push(2'b01, x, 16'h0, 2, "R10");
                    rac = ref_mem[x[9:1]];
                    gap = 2;
                end
                5'b00110: rac = rac & {6'b0, x};
                5'b00111: rac = rac + {6'b0, x};
                default: ;
            endcase
        end
    endtask

    // Monitor: pops expected requests and compares as the core issues them
    always @(negedge clk) begin
        cyc++;
        if (mon_en && rst_n && mem_op != 2'b00) begin
            if (sb.size() > 0) begin
                sb_item_t e;
                e = sb.pop_front();
                check(mem_op == e.op, "R11", "mem op code", mem_op, e.op);
                check(mem_addr == e.addr, e.req, "request address", mem_addr, e.addr);
                if (e.op == 2'b10)
                    check(mem_wdata == e.data, e.req, "write data", mem_wdata, e.data);
                if (e.gap > 0)
                    check((cyc - last_cyc) == e.gap, "R3", "cycles between requests",
                          cyc - last_cyc, e.gap);
            end
            last_cyc = cyc;
        end
    end

    task automatic run_prog(int n);
        int t;
        sb.delete();
        model_run(n);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(mem_op == 2'b00, "R1", "op during reset", mem_op, 0);
        end
        mon_en = 1'b1;
        rst_n  = 1'b1;
        t = 0;
        while (sb.size() > 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (sb.size() > 0)
            check(1'b0, "R3", "scoreboard drain timeout", sb.size(), 0);
        repeat (4) @(negedge clk);
        mon_en = 1'b0;
    endtask

    initial begin
        // Division by repeated subtraction: 13 / 4
        clear_mem();
        put(0,  enc(0, 5'b00101, 10'd900));
        put(2,  enc(0, 5'b00000, 10'd0));
        put(4,  enc(0, 5'b00111, 10'd4));
        put(6,  enc(0, 5'b00000, 10'd0));
        put(8,  enc(0, 5'b00010, 10'd20));
        put(10, enc(0, 5'b00100, 10'd900));
        put(12, enc(0, 5'b00101, 10'd902));
        put(14, enc(0, 5'b00111, 10'd1));
        put(16, enc(0, 5'b00100, 10'd902));
        put(18, enc(0, 5'b00011, 10'd0));
        put(20, enc(0, 5'b00101, 10'd900));
        put(22, enc(0, 5'b00100, 10'd904));
        put(24, enc(0, 5'b00011, 10'd24));
        put(900, 16'd13);
        put(902, 16'd0);
        put(904, 16'd0);
        run_prog(40);
        check(mem[451] == 16'd3, "R8", "quotient", mem[451], 3);
        check(mem[452] == 16'd1, "R10", "remainder", mem[452], 1);
        check(mem[450] == 16'd1, "R9", "stored dividend", mem[450], 1);

        // Operation coverage program
        clear_mem();
        put(0,  enc(0, 5'b00110, 10'd0));
        put(2,  enc(0, 5'b00111, 10'h3FF));
        put(4,  enc(0, 5'b00000, 10'd0));
        put(6,  enc(0, 5'b00100, 10'd800));
        put(8,  enc(0, 5'b00001, 10'd0));
        put(10, enc(0, 5'b00100, 10'd802));
        put(12, enc(0, 5'b00010, 10'd40));
        put(14, enc(0, 5'b00000, 10'd0));
        put(16, enc(0, 5'b00010, 10'd22));
        put(18, enc(0, 5'b00100, 10'd804));
        put(20, enc(0, 5'b00011, 10'd20));
        put(22, enc(0, 5'b00100, 10'd806));
        put(24, enc(1, 5'b00111, 10'd5));
        put(26, enc(0, 5'b00100, 10'd808));
        put(28, enc(0, 5'b01010, 10'h3FF));
        put(30, enc(0, 5'b00100, 10'd810));
        put(32, enc(0, 5'b00001, 10'd0));
        put(34, enc(0, 5'b00100, 10'd812));
        put(36, enc(0, 5'b00110, 10'd0));
        put(38, enc(0, 5'b00000, 10'd0));
        put(40, enc(0, 5'b00111, 10'd2));
        put(42, enc(0, 5'b00100, 10'd814));
        put(44, enc(0, 5'b00000, 10'd0));
        put(46, enc(0, 5'b00110, 10'h2F0));
        put(48, enc(0, 5'b00100, 10'd816));
        put(50, enc(0, 5'b00011, 10'd50));
        run_prog(26);
        check(mem[400] == 16'hFC00, "R4", "complement result", mem[400], 16'hFC00);
        check(mem[401] == 16'h7E00, "R5", "shift of positive", mem[401], 16'h7E00);
        check(mem[402] == 16'hDEAD, "R7", "skipped store untouched", mem[402], 16'hDEAD);
        check(mem[403] == 16'h81FF, "R7", "value after taken branch", mem[403], 16'h81FF);
        check(mem[404] == 16'h8204, "R2", "flagged add as direct", mem[404], 16'h8204);
        check(mem[405] == 16'h8204, "R12", "undefined opcode no effect", mem[405], 16'h8204);
        check(mem[406] == 16'h4102, "R5", "shift of negative zero-fills", mem[406], 16'h4102);
        check(mem[407] == 16'h0001, "R6", "add wraps", mem[407], 16'h0001);
        check(mem[408] == 16'h02F0, "R6", "and with zero-extended X", mem[408], 16'h02F0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #1500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog expired: actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule